// File: doc/BRIEF.md
# Two-Level Interrupt Controller with Programmable Arbiter Tree

This block gathers 32 primary request lines and 11 secondary request lines into a single normal interrupt output and a single fast interrupt output for a processor core. Every request is captured in a sticky pending register that software clears by writing 1. Secondary lines have their own pending and mask registers. An unmasked secondary pending bit keeps its parent primary pending bit set.

Primary sources that are pending, unmasked and not in fast mode compete in a two-level tree of six arbiters. Five group arbiters each cover seven consecutive source slots, and one top arbiter orders the five group winners. Each arbiter has a select field that names its highest-priority input, and it can rotate after every grant. The winner is loaded into a one-hot in-service register, but only while that register is empty. Its binary index is shown in an offset register. One source may be marked as fast. It skips the tree and drives the fast output directly.

Top module: `irq_two_level_ctrl`

## Requirements
- R1: A high `req_i[n]` at a clock edge sets pending bit n. The bit stays set after the request drops. Writing 1 to bit n at word address 0 clears it, unless the request is still high.
- R2: A high `sub_req_i[s]` sets sub-pending bit s at word address 6. The bit is sticky and is cleared by writing 1 to it.
- R3: While sub-mask bit s (word address 7, 1 = blocked) is 0 and sub-pending bit s is 1, the parent primary pending bit is set on every edge. The parents are: secondaries 0-2 feed source 28, 3-5 feed 23, 6-8 feed 15, and 9-10 feed 9. A blocked secondary sets no parent bit.
- R4: A primary source whose mask bit (word address 2, 1 = blocked) is set never enters the in-service register, and it never drives `fiq_o`. Its pending bit is still recorded.
- R5: The mode register (word address 1) holds at most one set bit, because a write keeps only the lowest set bit of the written data. The fast source drives `fiq_o` combinationally while it is pending and unmasked. It never takes part in arbitration.
- R6: The in-service register (word address 4) is one-hot or zero. It loads the arbitration winner one edge after a candidate exists, and only while it is empty. Writing 1 to its set bit empties it. The offset register (word address 5) reads the index of that bit, or 0 when the register is empty.
- R7: `irq_o` is 1 exactly when the in-service register is nonzero.
- R8: Group arbiter g covers sources 7g to 7g+6. Each arbiter gives its highest priority to the input named by its select field, then the following inputs in ascending order, wrapping around. The top arbiter orders the groups the same way. In the priority word (word address 3), arbiter k's select field sits at bits 8+3k to 10+3k. Arbiter 5 is the top arbiter.
- R9: Bit k of the priority word enables rotation for arbiter k. On each load, every arbiter that took part in the grant with rotation enabled sets its select field to its granted input + 1, modulo its width.
- R10: After reset, the mask and sub-mask are all ones. Every other register reads 0, and `irq_o` and `fiq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 32 | Primary request lines, level |
| sub_req_i | input | 11 | Secondary request lines, level |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A corrupted select field or rotation step shows at the offset register when the next source is loaded. That is one edge after software empties the in-service register. A broken load-when-empty rule shows as a higher-priority source replacing a source already in service before it is cleared. A broken sub-mask path shows as a missing or extra parent pending bit two edges after the secondary request. A multi-bit mode write reads back at once with more than one bit set, and a fast source can then reach the in-service register.

// File: rtl/irq2_pkg.sv
package irq2_pkg;
  localparam int NSRC = 32;
  localparam int NSUB = 11;
  localparam int GW   = 7;
  localparam int NGRP = 5;
  localparam int SELW = 3;
  localparam int DW   = 32;
  localparam int AW   = 3;
  localparam int SEL_BASE = 8;

  typedef enum logic [AW-1:0] {
    A_PEND = 3'd0,
    A_MODE = 3'd1,
    A_MASK = 3'd2,
    A_PRIO = 3'd3,
    A_INSV = 3'd4,
    A_OFS  = 3'd5,
    A_SPND = 3'd6,
    A_SMSK = 3'd7
  } reg_addr_e;

  // parent primary source of each secondary line
  function automatic int sub_parent(input int s);
    if (s < 3)      return 28;
    else if (s < 6) return 23;
    else if (s < 9) return 15;
    else            return 9;
  endfunction
endpackage

// File: rtl/irq2_arb.sv
module irq2_arb #(
  parameter int W    = 7,
  parameter int SELW = 3,
  localparam int IW  = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]    req_i,
  input  logic [SELW-1:0] sel_i,
  output logic            valid_o,
  output logic [IW-1:0]   idx_o
);
  // scan from furthest to nearest so the first input after sel wins
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int k = W - 1; k >= 0; k--) begin
      int p;
      p = (int'(sel_i) + k) % W;
      if (req_i[p]) begin
        valid_o = 1'b1;
        idx_o   = IW'(p);
      end
    end
  end
endmodule

// File: rtl/irq2_sub.sv
module irq2_sub
  import irq2_pkg::*;
#(
  parameter int NS = NSUB,
  parameter int NP = NSRC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NS-1:0] sub_req_i,
  input  logic          clr_we_i,
  input  logic [NS-1:0] clr_data_i,
  input  logic [NS-1:0] smask_i,
  output logic [NS-1:0] spend_o,
  output logic [NP-1:0] prim_set_o
);
  logic [NS-1:0] spend_q, clr;

  assign clr = clr_we_i ? clr_data_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) spend_q <= '0;
    else         spend_q <= (spend_q & ~clr) | sub_req_i;
  end

  always_comb begin
    prim_set_o = '0;
    for (int s = 0; s < NS; s++)
      if (spend_q[s] && !smask_i[s]) prim_set_o[sub_parent(s)] = 1'b1;
  end

  assign spend_o = spend_q;

  a_r2_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> ((spend_q & $past(spend_q)) == $past(spend_q)));
  a_r2_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && sub_req_i == '0) |=> ((spend_q & $past(clr_data_i)) == '0));
endmodule

// File: rtl/irq2_arb_tree.sv
module irq2_arb_tree #(
  parameter int NSRC = 32,
  parameter int GW   = 7,
  parameter int NGRP = 5,
  parameter int SELW = 3,
  localparam int SW  = $clog2(NSRC),
  localparam int LIW = $clog2(GW),
  localparam int GIW = $clog2(NGRP),
  localparam int PADW = NGRP * GW
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NSRC-1:0]           cand_i,
  input  logic [NGRP:0][SELW-1:0]   sel_i,
  output logic                      valid_o,
  output logic [SW-1:0]             src_o,
  output logic [GIW-1:0]            grp_o,
  output logic [LIW-1:0]            loc_o
);
  logic [PADW-1:0]           pad;
  logic [NGRP-1:0]           gv;
  logic [NGRP-1:0][LIW-1:0]  gi;

  always_comb begin
    pad = '0;
    pad[NSRC-1:0] = cand_i;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    irq2_arb #(.W(GW), .SELW(SELW)) u_arb (
      .req_i  (pad[g*GW +: GW]),
      .sel_i  (sel_i[g]),
      .valid_o(gv[g]),
      .idx_o  (gi[g])
    );
  end

  irq2_arb #(.W(NGRP), .SELW(SELW)) u_top (
    .req_i  (gv),
    .sel_i  (sel_i[NGRP]),
    .valid_o(valid_o),
    .idx_o  (grp_o)
  );

  assign loc_o = gi[grp_o];
  assign src_o = SW'(int'(grp_o) * GW + int'(gi[grp_o]));

  a_r8_gnt_is_cand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> cand_i[src_o]);
  a_r8_no_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_i != '0) |-> valid_o);
endmodule

// File: rtl/irq_two_level_ctrl.sv
module irq_two_level_ctrl
  import irq2_pkg::*;
#(
  parameter int N_SRC  = NSRC,
  parameter int N_SUB  = NSUB,
  parameter int G_W    = GW,
  parameter int N_GRP  = NGRP,
  parameter int S_W    = SELW,
  parameter int D_W    = DW,
  parameter int A_W    = AW,
  localparam int NARB  = N_GRP + 1,
  localparam int SRCW  = $clog2(N_SRC),
  localparam int LIW   = $clog2(G_W),
  localparam int GIW   = $clog2(N_GRP)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SUB-1:0] sub_req_i,
  input  logic             we_i,
  input  logic [A_W-1:0]   addr_i,
  input  logic [D_W-1:0]   wdata_i,
  output logic [D_W-1:0]   rdata_o,
  output logic             irq_o,
  output logic             fiq_o
);
  logic [N_SRC-1:0]          pend_q, mode_q, mask_q, insv_q, sub_set, cand;
  logic [N_SUB-1:0]          smask_q, spend;
  logic [NARB-1:0]           rot_q;
  logic [NARB-1:0][S_W-1:0]  sel_q;
  logic [SRCW-1:0]           ofs_q, win_src;
  logic [GIW-1:0]            win_grp;
  logic [LIW-1:0]            win_loc;
  logic                      win_valid, load;
  logic wr_pend, wr_mode, wr_mask, wr_prio, wr_insv, wr_spnd, wr_smsk;
  logic [D_W-1:0]            prio_word;
  logic [N_SRC-1:0]          insv_nx;

  assign wr_pend = we_i && addr_i == A_PEND;
  assign wr_mode = we_i && addr_i == A_MODE;
  assign wr_mask = we_i && addr_i == A_MASK;
  assign wr_prio = we_i && addr_i == A_PRIO;
  assign wr_insv = we_i && addr_i == A_INSV;
  assign wr_spnd = we_i && addr_i == A_SPND;
  assign wr_smsk = we_i && addr_i == A_SMSK;

  irq2_sub #(.NS(N_SUB), .NP(N_SRC)) u_sub (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sub_req_i (sub_req_i),
    .clr_we_i  (wr_spnd),
    .clr_data_i(wdata_i[N_SUB-1:0]),
    .smask_i   (smask_q),
    .spend_o   (spend),
    .prim_set_o(sub_set)
  );

  assign cand  = pend_q & ~mask_q & ~mode_q;
  assign fiq_o = |(pend_q & ~mask_q & mode_q);
  assign irq_o = |insv_q;

  irq2_arb_tree #(.NSRC(N_SRC), .GW(G_W), .NGRP(N_GRP), .SELW(S_W)) u_tree (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cand_i (cand),
    .sel_i  (sel_q),
    .valid_o(win_valid),
    .src_o  (win_src),
    .grp_o  (win_grp),
    .loc_o  (win_loc)
  );

  assign load    = (insv_q == '0) && win_valid;
  assign insv_nx = insv_q & ~wdata_i[N_SRC-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      mode_q  <= '0;
      mask_q  <= '1;
      smask_q <= '1;
    end else begin
      pend_q <= (pend_q & ~(wr_pend ? wdata_i[N_SRC-1:0] : '0)) | req_i | sub_set;
      if (wr_mode) mode_q  <= wdata_i[N_SRC-1:0] & (~wdata_i[N_SRC-1:0] + 1'b1);
      if (wr_mask) mask_q  <= wdata_i[N_SRC-1:0];
      if (wr_smsk) smask_q <= wdata_i[N_SUB-1:0];
    end
  end

  // priority config; rotation on load overrides a same-cycle write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rot_q <= '0;
      sel_q <= '0;
    end else begin
      if (wr_prio) begin
        rot_q <= wdata_i[NARB-1:0];
        for (int k = 0; k < NARB; k++) sel_q[k] <= wdata_i[SEL_BASE + S_W*k +: S_W];
      end
      if (load) begin
        if (rot_q[win_grp])
          sel_q[win_grp] <= S_W'((int'(win_loc) + 1) % G_W);
        if (rot_q[NARB-1])
          sel_q[NARB-1] <= S_W'((int'(win_grp) + 1) % N_GRP);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      insv_q <= '0;
      ofs_q  <= '0;
    end else if (load) begin
      insv_q <= N_SRC'(1) << win_src;
      ofs_q  <= win_src;
    end else if (wr_insv) begin
      insv_q <= insv_nx;
      if (insv_nx == '0) ofs_q <= '0;
    end
  end

  always_comb begin
    prio_word = '0;
    prio_word[NARB-1:0] = rot_q;
    for (int k = 0; k < NARB; k++) prio_word[SEL_BASE + S_W*k +: S_W] = sel_q[k];
  end

  always_comb begin
    rdata_o = '0;
    unique case (reg_addr_e'(addr_i))
      A_PEND: rdata_o[N_SRC-1:0] = pend_q;
      A_MODE: rdata_o[N_SRC-1:0] = mode_q;
      A_MASK: rdata_o[N_SRC-1:0] = mask_q;
      A_PRIO: rdata_o = prio_word;
      A_INSV: rdata_o[N_SRC-1:0] = insv_q;
      A_OFS:  rdata_o[SRCW-1:0]  = ofs_q;
      A_SPND: rdata_o[N_SUB-1:0] = spend;
      A_SMSK: rdata_o[N_SUB-1:0] = smask_q;
      default: rdata_o = '0;
    endcase
  end

  a_r6_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(insv_q));
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insv_q != '0 && !wr_insv) |=> $stable(insv_q));
  a_r6_ofs_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insv_q != '0) |-> insv_q[ofs_q]);
  a_r6_ofs_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insv_q == '0) |-> (ofs_q == '0));
  a_r5_single_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mode_q) <= 1);
  a_r4_from_cand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insv_q == '0) |=> (insv_q == '0 || (insv_q & $past(pend_q & ~mask_q & ~mode_q)) != '0));
endmodule

// File: tb/sim_irq_two_level_ctrl.sv
`timescale 1ns/1ps
module sim_irq_two_level_ctrl;
  localparam int P_PEND = 0, P_MODE = 1, P_MASK = 2, P_PRIO = 3;
  localparam int P_INSV = 4, P_OFS = 5, P_SPND = 6, P_SMSK = 7;
  localparam int K_RD = 0, K_IRQ = 1, K_FIQ = 2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] req = '0;
  logic [10:0] sub_req = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, fiq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  irq_two_level_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .sub_req_i(sub_req),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .fiq_o(fiq)
  );

  // monitor: compares outputs against queued expectations
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      act = (it.kind == K_RD) ? rdata : (it.kind == K_IRQ) ? {31'b0, irq} : {31'b0, fiq};
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s act=%h exp=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic chk(input int kind, input int a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    addr = 3'(a);
    it.kind = kind; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = 3'(a); wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic pulse(input logic [31:0] v);
    @(posedge clk); #1; req = v;
    @(posedge clk); #1; req = '0;
  endtask

  task automatic sub_pulse(input logic [10:0] v);
    @(posedge clk); #1; sub_req = v;
    @(posedge clk); #1; sub_req = '0;
  endtask

  task automatic clean();
    wr(P_MASK, 32'hffff_ffff);
    wr(P_MODE, 32'h0);
    wr(P_PRIO, 32'h0);
    wr(P_SMSK, 32'h7ff);
    wr(P_SPND, 32'h7ff);
    wr(P_PEND, 32'hffff_ffff);
    wr(P_INSV, 32'hffff_ffff);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 reset state
    chk(K_RD, P_MASK, 32'hffff_ffff, "R10 mask");
    chk(K_RD, P_SMSK, 32'h7ff, "R10 smask");
    chk(K_RD, P_PEND, 32'h0, "R10 pend");
    chk(K_RD, P_INSV, 32'h0, "R10 insv");
    chk(K_IRQ, 0, 32'h0, "R10 irq");
    chk(K_FIQ, 0, 32'h0, "R10 fiq");

    // R1 / R4 / R6 / R7 basic path
    pulse(32'h1 << 5);
    chk(K_RD, P_PEND, 32'h1 << 5, "R1 pend sticky");
    chk(K_IRQ, 0, 32'h0, "R4 masked no irq");
    chk(K_RD, P_INSV, 32'h0, "R4 masked not served");
    wr(P_MASK, ~(32'h1 << 5));
    chk(K_RD, P_INSV, 32'h1 << 5, "R6 load");
    chk(K_RD, P_OFS, 32'd5, "R6 offset");
    chk(K_IRQ, 0, 32'h1, "R7 irq high");
    wr(P_PEND, 32'h1 << 5);
    chk(K_RD, P_PEND, 32'h0, "R1 w1c");
    wr(P_INSV, 32'h1 << 5);
    chk(K_RD, P_INSV, 32'h0, "R6 cleared");
    chk(K_RD, P_OFS, 32'h0, "R6 offset zero");
    chk(K_IRQ, 0, 32'h0, "R7 irq low");

    // R8 default ordering across groups
    clean();
    pulse((32'h1 << 3) | (32'h1 << 10) | (32'h1 << 20));
    wr(P_MASK, 32'h0);
    chk(K_RD, P_OFS, 32'd3, "R8 default group0 first");
    wr(P_PEND, 32'h1 << 3);
    wr(P_INSV, 32'h1 << 3);
    chk(K_RD, P_OFS, 32'd10, "R8 group1 next");
    wr(P_PEND, 32'h1 << 10);
    wr(P_INSV, 32'h1 << 10);
    chk(K_RD, P_OFS, 32'd20, "R8 group2 last");

    // R8 top select = group 2
    clean();
    pulse((32'h1 << 3) | (32'h1 << 10) | (32'h1 << 20));
    wr(P_PRIO, 32'd2 << 23);
    wr(P_MASK, 32'h0);
    chk(K_RD, P_OFS, 32'd20, "R8 top sel");

    // R8 group1 select 2 then 3 (wraparound)
    clean();
    pulse((32'h1 << 7) | (32'h1 << 9));
    wr(P_PRIO, 32'd2 << 11);
    wr(P_MASK, 32'h0);
    chk(K_RD, P_OFS, 32'd9, "R8 group sel start");
    clean();
    pulse((32'h1 << 7) | (32'h1 << 9));
    wr(P_PRIO, 32'd3 << 11);
    wr(P_MASK, 32'h0);
    chk(K_RD, P_OFS, 32'd7, "R8 group sel wrap");

    // R9 rotation in group 0
    clean();
    pulse((32'h1 << 1) | (32'h1 << 2));
    wr(P_PRIO, 32'h1);
    wr(P_MASK, 32'h0);
    chk(K_RD, P_INSV, 32'h1 << 1, "R9 first grant");
    chk(K_RD, P_PRIO, 32'h201, "R9 sel advanced");
    wr(P_INSV, 32'h1 << 1);
    chk(K_RD, P_INSV, 32'h1 << 2, "R9 serviced drops");
    chk(K_RD, P_PRIO, 32'h301, "R9 sel advanced again");

    // R6 load only when empty
    clean();
    wr(P_MASK, 32'h0);
    pulse(32'h1 << 20);
    chk(K_RD, P_INSV, 32'h1 << 20, "R6 first");
    pulse(32'h1 << 3);
    chk(K_RD, P_INSV, 32'h1 << 20, "R6 no preempt");
    wr(P_INSV, 32'h1 << 20);
    chk(K_RD, P_OFS, 32'd3, "R6 next after clear");

    // R5 fast mode
    clean();
    wr(P_MODE, (32'h1 << 12) | (32'h1 << 4));
    chk(K_RD, P_MODE, 32'h1 << 4, "R5 single mode bit");
    pulse(32'h1 << 4);
    chk(K_FIQ, 0, 32'h0, "R4 masked no fiq");
    wr(P_MASK, ~(32'h1 << 4));
    chk(K_FIQ, 0, 32'h1, "R5 fiq");
    chk(K_RD, P_INSV, 32'h0, "R5 not arbitrated");
    chk(K_IRQ, 0, 32'h0, "R5 no irq");
    wr(P_MASK, 32'hffff_ffff);
    chk(K_FIQ, 0, 32'h0, "R5 fiq masked");

    // R2 / R3 secondaries
    clean();
    sub_pulse(11'h1 << 4);
    chk(K_RD, P_SPND, 32'h1 << 4, "R2 sub sticky");
    chk(K_RD, P_PEND, 32'h0, "R3 blocked no parent");
    wr(P_SMSK, 32'h7ff & ~(32'h1 << 4));
    chk(K_RD, P_PEND, 32'h1 << 23, "R3 parent 23");
    wr(P_SMSK, 32'h7ff);
    wr(P_SPND, 32'h1 << 4);
    chk(K_RD, P_SPND, 32'h0, "R2 sub w1c");
    sub_pulse(11'h1 << 10);
    wr(P_PEND, 32'hffff_ffff);
    wr(P_SMSK, 32'h7ff & ~(32'h1 << 10));
    chk(K_RD, P_PEND, 32'h1 << 9, "R3 parent 9");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule